// File: doc/BRIEF.md
# Host Byte-Stream Bootstrap Loader

After reset this block fills a 24-bit program memory from a host that sends one byte at a time. Bytes come in over a valid/ready handshake. The block packs every three bytes into one 24-bit value, least significant byte first. The first value is the number of program words, the second is the load address, and each value after that is a program word. Each program word is written through a single-cycle write strobe, to consecutive addresses starting at the load address.

Four mode pins are captured once, on the first clock edge after reset is released. Loading runs only when the two upper captured bits are both set. The two lower bits name the host bus style, and this block only reports them; it does not act on them. When the last word has been written, the block gives a one-cycle completion pulse together with the load address, so the processor can begin executing there. The block then stays idle until the next reset.

Top module: `hbl_boot_loader`

## Requirements
- R1: `mode_pins` (bit 3 = D, bit 2 = C, bit 1 = B, bit 0 = A) is captured on the first rising clock edge after `rst_n` goes high. From then on `host_mode` = D&C and `bus_style` = {B,A}. Later changes on the pins have no effect until the next reset.
- R2: `in_ready` is high only while a host boot is receiving bytes: after the mode capture, and before completion.
- R3: The first three accepted bytes form the 24-bit word count, least significant byte first.
- R4: The next three accepted bytes form the 24-bit load address, least significant byte first.
- R5: Each program word is three bytes, least significant byte first. `mem_we` is high for exactly one cycle, in the cycle after the word's third byte is accepted, with `mem_wdata` holding the word.
- R6: The first word goes to the load address. Each later word goes to the previous address plus one, wrapping modulo 2^24.
- R7: `boot_done` is a one-cycle pulse, with `boot_addr` equal to the load address. It comes in the same cycle as the write of the last word.
- R8: With a count of zero, `boot_done` pulses in the cycle after the sixth byte is accepted, and no write takes place.
- R9: After `boot_done`, `in_ready` stays low. Further bytes cause no write and no further pulse until reset.
- R10: When `host_mode` is 0, `in_ready`, `mem_we` and `boot_done` stay low whatever the byte input does.
- R11: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. Idle gaps in `in_valid` do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 4 | Boot mode pins {D,C,B,A} |
| in_data | input | 8 | Host byte |
| in_valid | input | 1 | Host byte present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | 24 | Program memory write address |
| mem_wdata | output | 24 | Program memory write data |
| boot_done | output | 1 | Completion pulse |
| boot_addr | output | 24 | Address to start execution at |
| host_mode | output | 1 | Captured mode selects host boot |
| bus_style | output | 2 | Captured host bus style {B,A} |

## Verification
Suppose the byte lane index slips. The first write then carries bytes in the wrong lanes, so the error shows on `mem_wdata` one cycle after the third program byte. A fault in the count or the remaining-word counter shows as a completion pulse that comes early or late, or as a write after completion. A fault in the address register shows on `mem_addr` at the first write, or at the address wrap. A bad mode capture shows at once on `host_mode`, `bus_style` and `in_ready`, within two cycles of reset release.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_COUNT,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_OFF
  } hbl_state_e;

  // host boot is selected when the two upper mode bits are both set
  function automatic logic is_host_boot(input logic [3:0] m);
    return m[3] & m[2];
  endfunction

  function automatic logic is_receiving(input hbl_state_e s);
    return (s == ST_COUNT) || (s == ST_ADDR) || (s == ST_DATA);
  endfunction
endpackage

// File: rtl/hbl_mode_latch.sv
module hbl_mode_latch #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] pins,
  output logic [MODE_W-1:0] mode_q,
  output logic              mode_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      mode_valid <= 1'b0;
    end else if (!mode_valid) begin
      mode_q     <= pins;
      mode_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/hbl_byte_packer.sv
module hbl_byte_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_fire,
  output logic [WORD_W-1:0] word_out
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] acc_q;

  // new byte enters at the top, older bytes move down: LSB-first order
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return {b, acc[WORD_W-1:BYTE_W]};
  endfunction

  assign word_out  = shift_in(acc_q, byte_in);
  assign word_fire = take && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      acc_q <= word_out;
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/hbl_sequencer.sv
module hbl_sequencer
  import hbl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_valid,
  input  logic              host_sel,
  input  logic              word_fire,
  input  logic [WORD_W-1:0] word_in,
  output hbl_state_e        state,
  output logic              rx_ready,
  output logic              we,
  output logic [WORD_W-1:0] waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              done,
  output logic [WORD_W-1:0] jump_addr
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] count_q, remain_q, next_addr_q, start_q;

  assign rx_ready = is_receiving(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_WAIT;
      count_q     <= '0;
      remain_q    <= '0;
      next_addr_q <= '0;
      start_q     <= '0;
      we          <= 1'b0;
      waddr       <= '0;
      wdata       <= '0;
      done        <= 1'b0;
      jump_addr   <= '0;
    end else begin
      we   <= 1'b0;
      done <= 1'b0;
      case (state)
        ST_WAIT: if (mode_valid) state <= host_sel ? ST_COUNT : ST_OFF;
        ST_COUNT: if (word_fire) begin
          count_q <= word_in;
          state   <= ST_ADDR;
        end
        ST_ADDR: if (word_fire) begin
          start_q     <= word_in;
          next_addr_q <= word_in;
          remain_q    <= count_q;
          if (count_q == '0) begin
            done      <= 1'b1;
            jump_addr <= word_in;
            state     <= ST_END;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_DATA: if (word_fire) begin
          we          <= 1'b1;
          waddr       <= next_addr_q;
          wdata       <= word_in;
          next_addr_q <= next_addr_q + ONE;
          remain_q    <= remain_q - ONE;
          if (remain_q == ONE) begin
            done      <= 1'b1;
            jump_addr <= start_q;
            state     <= ST_END;
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/hbl_boot_loader.sv
module hbl_boot_loader
  import hbl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              boot_done,
  output logic [WORD_W-1:0] boot_addr,
  output logic              host_mode,
  output logic [1:0]        bus_style
);
  logic [MODE_W-1:0] mode_q;
  logic              mode_valid;
  logic              byte_take;
  logic              word_fire;
  logic [WORD_W-1:0] word_val;
  hbl_state_e        state;

  hbl_mode_latch #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .pins(mode_pins),
    .mode_q(mode_q), .mode_valid(mode_valid)
  );

  assign host_mode = mode_valid & is_host_boot(mode_q[3:0]);
  assign bus_style = mode_q[1:0];
  assign byte_take = in_valid & in_ready;

  hbl_byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(byte_take), .byte_in(in_data),
    .word_fire(word_fire), .word_out(word_val)
  );

  hbl_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .host_sel(host_mode),
    .word_fire(word_fire), .word_in(word_val), .state(state),
    .rx_ready(in_ready), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .done(boot_done), .jump_addr(boot_addr)
  );
endmodule

// File: rtl/hbl_boot_loader_sva.sv
module hbl_boot_loader_sva #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_valid,
  input logic              host_mode,
  input logic [1:0]        bus_style,
  input logic              in_ready,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic              boot_done
);
  logic              wrote_q, finished_q;
  logic [WORD_W-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrote_q     <= 1'b0;
      finished_q  <= 1'b0;
      last_addr_q <= '0;
    end else begin
      if (mem_we) begin
        wrote_q     <= 1'b1;
        last_addr_q <= mem_addr;
      end
      if (boot_done) finished_q <= 1'b1;
    end
  end

  assert_mode_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_valid) |-> ($stable(host_mode) && $stable(bus_style)));
  assert_ready_host_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> host_mode);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wrote_q) |-> (mem_addr == last_addr_q + WORD_W'(1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finished_q |-> (!in_ready && !mem_we && !boot_done));
  assert_offmode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |-> (!mem_we && !boot_done));
endmodule

bind hbl_boot_loader hbl_boot_loader_sva #(.WORD_W(WORD_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .host_mode(host_mode),
  .bus_style(bus_style), .in_ready(in_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .boot_done(boot_done)
);

// File: tb/hbl_boot_loader_tb.sv
module hbl_boot_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_pins = 4'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_valid = 1'b0;
  logic        in_ready, mem_we, boot_done, host_mode;
  logic [23:0] mem_addr, mem_wdata, boot_addr;
  logic [1:0]  bus_style;

  int tests = 0;
  int fails = 0;
  logic [47:0] exp_q[$];
  logic [23:0] exp_jump;
  int done_cnt;
  int write_cnt;

  always #2.5 clk = ~clk;

  hbl_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .boot_done(boot_done),
    .boot_addr(boot_addr), .host_mode(host_mode), .bus_style(bus_style)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected writes, checks completion address
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      write_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R6", "unexpected write", {mem_addr, mem_wdata}, 48'h0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R6", "write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
    if (rst_n && boot_done) begin
      done_cnt++;
      check(boot_addr == exp_jump, "R7", "jump address", {24'h0, boot_addr}, {24'h0, exp_jump});
    end
  end

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = m; in_valid = 1'b0;
    exp_q.delete(); done_cnt = 0; write_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // at a negedge: present byte, wait for acceptance, return at next negedge
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] w, input int gap);
    for (int i = 0; i < 3; i++) begin
      send_byte(w[8*i +: 8]);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send_prog(input logic [23:0] addr, input logic [23:0] w, input int gap);
    exp_q.push_back({addr, w});
    send_byte(w[7:0]);   repeat (gap) @(negedge clk);
    send_byte(w[15:8]);  repeat (gap) @(negedge clk);
    send_byte(w[23:16]);
    // R5: strobe is up exactly one cycle after the third byte
    check(mem_we == 1'b1 && mem_wdata == w, "R5", "write one cycle after third byte",
          {23'h0, mem_we, mem_wdata}, {24'h1, w});
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // scenario 1: mode 1100, three words
    do_reset(4'b1100);
    check(!in_ready && !mem_we && !boot_done, "R2", "quiet right after reset",
          {45'h0, in_ready, mem_we, boot_done}, 48'h0);
    repeat (2) @(negedge clk);
    mode_pins = 4'b0011;
    @(negedge clk);
    check(host_mode == 1'b1 && bus_style == 2'b00, "R1", "capture ignores later pins",
          {45'h0, host_mode, bus_style}, 48'h4);
    check(in_ready == 1'b1, "R2", "ready in host boot", {47'h0, in_ready}, 48'h1);
    exp_jump = 24'h000100;
    send_word(24'h000003, 0);   // R3 count
    send_word(24'h000100, 0);   // R4 address
    send_prog(24'h000100, 24'h123456, 0);
    send_prog(24'h000101, 24'hA5A5A5, 0);
    check(done_cnt == 0, "R7", "no completion before last word", done_cnt, 0);
    send_prog(24'h000102, 24'h00FF01, 0);
    check(boot_done == 1'b1, "R7", "done with last write", {47'h0, boot_done}, 48'h1);
    @(negedge clk);
    check(done_cnt == 1 && exp_q.size() == 0, "R7", "one pulse, all writes",
          {16'h0, done_cnt[15:0], 8'h0, 8'(exp_q.size())}, {16'h0, 16'h1, 16'h0});

    // scenario 2: mode 1111, zero count, then extra bytes
    do_reset(4'b1111);
    exp_jump = 24'hABCDEF;
    send_word(24'h000000, 0);
    send_word(24'hABCDEF, 0);
    check(boot_done == 1'b1 && boot_addr == 24'hABCDEF, "R8", "zero count done after address",
          {23'h0, boot_done, boot_addr}, {24'h1, 24'hABCDEF});
    in_valid = 1'b1; in_data = 8'h55;
    repeat (6) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R9", "ready low after done", {47'h0, in_ready}, 48'h0);
    end
    in_valid = 1'b0;
    check(write_cnt == 0 && done_cnt == 1, "R9", "no write, single pulse",
          {16'h0, write_cnt[15:0], done_cnt[15:0]}, {32'h0, 16'h1});

    // scenario 3: non-host mode 0111
    do_reset(4'b0111);
    in_valid = 1'b1; in_data = 8'h03;
    repeat (2) @(negedge clk);
    check(host_mode == 1'b0 && bus_style == 2'b11, "R1", "non-host capture",
          {45'h0, host_mode, bus_style}, 48'h3);
    repeat (8) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R10", "ready stays low", {47'h0, in_ready}, 48'h0);
    end
    in_valid = 1'b0;
    check(write_cnt == 0 && done_cnt == 0, "R10", "no write or done",
          {16'h0, write_cnt[15:0], done_cnt[15:0]}, 48'h0);

    // scenario 4: mode 1110, gaps in valid, address wrap
    do_reset(4'b1110);
    repeat (2) @(negedge clk);
    check(bus_style == 2'b10, "R1", "bus style", {46'h0, bus_style}, 48'h2);
    exp_jump = 24'hFFFFFF;
    send_word(24'h000002, 2);   // R11 gaps
    send_word(24'hFFFFFF, 1);
    send_prog(24'hFFFFFF, 24'h0C0B0A, 3);
    send_prog(24'h000000, 24'h807060, 1);
    @(negedge clk);
    check(done_cnt == 1 && write_cnt == 2 && exp_q.size() == 0, "R11", "gapped load complete",
          {16'(done_cnt), 16'(write_cnt), 16'(exp_q.size())}, {16'h1, 16'h2, 16'h0});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule